// File: doc/BRIEF.md
# Clock Pulse Count Write Guard

This block sits beside the command decoder of a serial three-wire memory slave and decides whether a write-class command is allowed to run. From the moment the start bit is recognised until chip select falls, it tallies the rising serial-clock edges. The tally includes the clock that sampled the start bit.

When chip select falls, the block compares the tally with the exact length that the latched command should have. That length depends on the command and on the organisation mode. A match raises a one-cycle execute pulse. Any difference, even a single extra clock caused by a glitch, raises a one-cycle reject pulse instead. A glitch shifts the address and data by one bit, so a rejected command never reaches the array and never sets the busy flag.

Read and the non-programming commands pass through the guard without any verdict. All inputs are single-cycle strobes in the system clock domain, produced by an edge detector upstream.

Top module: `clkcount_write_guard`

## Requirements
- R1: While reset is asserted, and until the first decision after reset, `exec_o` and `reject_o` are both 0.
- R2: In narrow mode (`org_wide_i`=0), a WRITE (`cmd_i`=1) whose tally is exactly 20 gives `exec_o`=1 for one cycle. The pulse appears in the cycle after the `cs_fall_i` strobe.
- R3: In wide mode (`org_wide_i`=1), a WRITE whose tally is exactly 27 gives `exec_o`=1 for one cycle, in the cycle after `cs_fall_i`.
- R4: A guarded command whose tally differs from its expected length by any amount gives `reject_o`=1 for one cycle after `cs_fall_i`, and no `exec_o`.
- R5: ERASE (`cmd_i`=2) and ERASE-ALL (`cmd_i`=3) expect a tally of 12 in narrow mode and 11 in wide mode.
- R6: WRITE-ALL (`cmd_i`=4) expects the same tally as WRITE: 20 in narrow mode and 27 in wide mode.
- R7: READ (`cmd_i`=0), write-enable (5), write-disable (6) and the spare code (7) never produce `exec_o` or `reject_o`, whatever the tally.
- R8: The tally saturates one above the longest expected length. A run of 52 clocks in narrow mode is therefore rejected and does not wrap round to 20.
- R9: A `cs_fall_i` with no `start_i` since the previous `cs_fall_i` produces no verdict.
- R10: A new `start_i` restarts the tally at 1. `exec_o` and `reject_o` are never high together.
- R11: The tally counts the start clock as 1. A `sck_rise_i` in the same cycle as `cs_fall_i` is counted toward the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start bit recognised on this cycle (counts as clock 1) |
| sck_rise_i | input | 1 | Rising serial-clock edge strobe |
| cs_fall_i | input | 1 | Chip-select falling edge strobe |
| cmd_i | input | 3 | Decoded command class, valid at `cs_fall_i` |
| org_wide_i | input | 1 | 1 = 16-bit word organisation, 0 = 8-bit byte organisation |
| exec_o | output | 1 | One-cycle permission to start the programming cycle |
| reject_o | output | 1 | One-cycle notice that the command was suppressed |

## Verification
The assertions take for granted that `start_i` and `cs_fall_i` never arrive in the same cycle, and that `cmd_i` and `org_wide_i` are stable when `cs_fall_i` is high. The stimulus respects both. It sends each instruction as a start strobe, then separated clock strobes, then a lone fall strobe, with the command and mode held steady throughout. The lengths are taken one below, at and one above each expected value. Further cases cover a long overrun, an aborted start and a final clock that coincides with the fall strobe.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_ERAL  = 3'd3,
    CMD_WRAL  = 3'd4,
    CMD_WEN   = 3'd5,
    CMD_WDS   = 3'd6,
    CMD_NONE  = 3'd7
  } cmd_e;

  // start bit plus two opcode bits
  localparam int unsigned HDR_LEN = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cwg_tally.sv
module cwg_tally #(
  parameter int unsigned CW  = 5,
  parameter int unsigned SAT = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rise,
  input  logic          fall,
  output logic [CW-1:0] tally_q,
  output logic [CW-1:0] tally_eff,
  output logic          armed_q
);

  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0] tally_inc;
  logic [CW-1:0] tally_d;
  logic          armed_d;
  logic          en;

  always_comb begin
    tally_inc = (tally_q >= SAT_V) ? SAT_V : tally_q + ONE_V;
    if (start) begin
      tally_eff = ONE_V;
    end else if (rise && armed_q) begin
      tally_eff = tally_inc;
    end else begin
      tally_eff = tally_q;
    end
  end

  always_comb begin
    armed_d = armed_q;
    tally_d = tally_q;
    if (start) begin
      armed_d = 1'b1;
      tally_d = ONE_V;
    end else if (fall) begin
      armed_d = 1'b0;
      tally_d = '0;
    end else if (rise && armed_q) begin
      tally_d = tally_inc;
    end
  end

  assign en = start | rise | fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_q <= '0;
      armed_q <= 1'b0;
    end else if (en) begin
      tally_q <= tally_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/cwg_length.sv
module cwg_length
  import cwg_pkg::*;
#(
  parameter int unsigned CW          = 5,
  parameter int unsigned ADDR_W_WIDE = 8,
  parameter int unsigned DATA_W_WIDE = 16
) (
  input  cmd_e          cmd,
  input  logic          wide,
  output logic          guarded,
  output logic [CW-1:0] expect_len
);

  localparam int unsigned ADDR_W_NARROW = ADDR_W_WIDE + 1;
  localparam int unsigned DATA_W_NARROW = DATA_W_WIDE / 2;

  localparam logic [CW-1:0] WR_WIDE   = CW'(HDR_LEN + ADDR_W_WIDE + DATA_W_WIDE);
  localparam logic [CW-1:0] WR_NARROW = CW'(HDR_LEN + ADDR_W_NARROW + DATA_W_NARROW);
  localparam logic [CW-1:0] ER_WIDE   = CW'(HDR_LEN + ADDR_W_WIDE);
  localparam logic [CW-1:0] ER_NARROW = CW'(HDR_LEN + ADDR_W_NARROW);

  logic [CW-1:0] wr_len;
  logic [CW-1:0] er_len;

  always_comb begin
    wr_len = wide ? WR_WIDE : WR_NARROW;
    er_len = wide ? ER_WIDE : ER_NARROW;
    unique case (cmd)
      CMD_WRITE, CMD_WRAL: begin
        guarded    = 1'b1;
        expect_len = wr_len;
      end
      CMD_ERASE, CMD_ERAL: begin
        guarded    = 1'b1;
        expect_len = er_len;
      end
      default: begin
        guarded    = 1'b0;
        expect_len = '0;
      end
    endcase
  end

endmodule

// File: rtl/cwg_verdict.sv
module cwg_verdict #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          armed,
  input  logic          guarded,
  input  logic [CW-1:0] tally_eff,
  input  logic [CW-1:0] expect_len,
  output logic          exec_q,
  output logic          reject_q
);

  logic judge;
  logic match;
  logic exec_d;
  logic reject_d;

  always_comb begin
    judge    = fall & armed & guarded;
    match    = (tally_eff == expect_len);
    exec_d   = judge & match;
    reject_d = judge & ~match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      exec_q   <= exec_d;
      reject_q <= reject_d;
    end
  end

endmodule

// File: rtl/clkcount_write_guard.sv
module clkcount_write_guard
  import cwg_pkg::*;
#(
  parameter int unsigned ADDR_W_WIDE = 8,
  parameter int unsigned DATA_W_WIDE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sck_rise_i,
  input  logic       cs_fall_i,
  input  logic [2:0] cmd_i,
  input  logic       org_wide_i,
  output logic       exec_o,
  output logic       reject_o
);

  localparam int unsigned LEN_WR_WIDE   = HDR_LEN + ADDR_W_WIDE + DATA_W_WIDE;
  localparam int unsigned LEN_WR_NARROW = HDR_LEN + ADDR_W_WIDE + 1 + DATA_W_WIDE / 2;
  localparam int unsigned MAX_LEN       = max2(LEN_WR_WIDE, LEN_WR_NARROW);
  localparam int unsigned SAT           = MAX_LEN + 1;
  localparam int unsigned CW            = $clog2(SAT + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [CW-1:0] tally_q;
  logic [CW-1:0] tally_eff;
  logic          armed_q;
  logic          guarded;
  logic [CW-1:0] expect_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  cwg_tally #(.CW(CW), .SAT(SAT)) u_tally (
    .clk       (clk_i),
    .rst_n     (rst_n_s),
    .start     (start_i),
    .rise      (sck_rise_i),
    .fall      (cs_fall_i),
    .tally_q   (tally_q),
    .tally_eff (tally_eff),
    .armed_q   (armed_q)
  );

  cwg_length #(
    .CW          (CW),
    .ADDR_W_WIDE (ADDR_W_WIDE),
    .DATA_W_WIDE (DATA_W_WIDE)
  ) u_length (
    .cmd        (cmd_e'(cmd_i)),
    .wide       (org_wide_i),
    .guarded    (guarded),
    .expect_len (expect_len)
  );

  cwg_verdict #(.CW(CW)) u_verdict (
    .clk        (clk_i),
    .rst_n      (rst_n_s),
    .fall       (cs_fall_i),
    .armed      (armed_q),
    .guarded    (guarded),
    .tally_eff  (tally_eff),
    .expect_len (expect_len),
    .exec_q     (exec_o),
    .reject_q   (reject_o)
  );

endmodule

// File: rtl/cwg_chk.sv
module cwg_chk #(
  parameter int unsigned ADDR_W_WIDE = 8,
  parameter int unsigned DATA_W_WIDE = 16,
  parameter int unsigned CW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          fall,
  input logic [2:0]    cmd,
  input logic          wide,
  input logic          armed,
  input logic [CW-1:0] tally_q,
  input logic [CW-1:0] tally_eff,
  input logic          exec,
  input logic          reject
);

  localparam int unsigned WR_W = 3 + ADDR_W_WIDE + DATA_W_WIDE;
  localparam int unsigned WR_N = 3 + ADDR_W_WIDE + 1 + DATA_W_WIDE / 2;
  localparam int unsigned ER_N = 3 + ADDR_W_WIDE + 1;
  localparam int unsigned SATV = ((WR_W > WR_N) ? WR_W : WR_N) + 1;

  logic judged;
  logic grd_cmd;
  assign judged  = fall && armed && !start;
  assign grd_cmd = (cmd >= 3'd1) && (cmd <= 3'd4);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && reject));

  a_r9_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (exec || reject) |-> $past(fall));

  a_r9_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !armed && !start) |=> (!exec && !reject));

  a_r7_unguarded_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !grd_cmd) |=> (!exec && !reject));

  a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tally_q) <= SATV);

  a_r2_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (judged && cmd == 3'd1 && !wide && int'(tally_eff) == WR_N) |=> exec);

  a_r3_wide_write: assert property (@(posedge clk) disable iff (!rst_n)
    (judged && cmd == 3'd1 && wide && int'(tally_eff) == WR_W) |=> exec);

  a_r4_narrow_write_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (judged && cmd == 3'd1 && !wide && int'(tally_eff) != WR_N) |=> (reject && !exec));

  a_r5_narrow_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (judged && cmd == 3'd2 && !wide && int'(tally_eff) == ER_N) |=> exec);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (armed && int'(tally_q) == 1));

endmodule

bind clkcount_write_guard cwg_chk #(
  .ADDR_W_WIDE (ADDR_W_WIDE),
  .DATA_W_WIDE (DATA_W_WIDE),
  .CW          (CW)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n_s),
  .start     (start_i),
  .fall      (cs_fall_i),
  .cmd       (cmd_i),
  .wide      (org_wide_i),
  .armed     (armed_q),
  .tally_q   (tally_q),
  .tally_eff (tally_eff),
  .exec      (exec_o),
  .reject    (reject_o)
);

// File: tb/clkcount_write_guard_tb.sv
module clkcount_write_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, rise, fall, org;
  logic [2:0] cmd;
  logic       exec_w, reject_w;

  int n_checks = 0;
  int n_fails  = 0;

  int  m_cnt   = 0;
  bit  m_armed = 1'b0;
  bit  m_exec  = 1'b0;
  bit  m_rej   = 1'b0;

  always #2.5 clk = ~clk;

  clkcount_write_guard u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .sck_rise_i (rise),
    .cs_fall_i  (fall),
    .cmd_i      (cmd),
    .org_wide_i (org),
    .exec_o     (exec_w),
    .reject_o   (reject_w)
  );

  // expected lengths straight from the requirements: R2 R3 R5 R6; -1 = unguarded (R7)
  function automatic int want_len(input logic [2:0] k, input logic w);
    case (k)
      3'd1, 3'd4: return w ? 27 : 20;
      3'd2, 3'd3: return w ? 11 : 12;
      default:    return -1;
    endcase
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (exec_w !== m_exec || reject_w !== m_rej) begin
      n_fails++;
      $display("FAIL %s: exec/reject = %b/%b expected %b/%b at %0t",
               tag, exec_w, reject_w, m_exec, m_rej, $time);
    end
  endtask

  // drive at negedge, update model at posedge, compare at following negedge
  task automatic step(input logic s, input logic r, input logic f, input string tag);
    int eff;
    int len;
    start = s; rise = r; fall = f;
    @(posedge clk);
    eff    = s ? 1 : (m_cnt + ((r && m_armed) ? 1 : 0));
    len    = want_len(cmd, org);
    m_exec = 1'b0;
    m_rej  = 1'b0;
    if (f && m_armed && len >= 0) begin
      m_exec = (eff == len);
      m_rej  = (eff != len);
    end
    if (s) begin
      m_armed = 1'b1; m_cnt = 1;
    end else if (f) begin
      m_armed = 1'b0; m_cnt = 0;
    end else if (r && m_armed) begin
      m_cnt++;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic send(input logic [2:0] k, input logic w, input int n,
                      input bit coinc, input string tag);
    cmd = k; org = w;
    step(1, 1, 0, tag);
    for (int i = 1; i < n; i++) begin
      if (coinc && i == n - 1) begin
        step(0, 1, 1, tag);
      end else begin
        step(0, 1, 0, tag);
        step(0, 0, 0, tag);
      end
    end
    if (!coinc) step(0, 0, 1, tag);
    for (int i = 0; i < 3; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    #1ms;
    n_fails++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; rise = 0; fall = 0; cmd = 3'd0; org = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R1 after reset");

    send(3'd1, 1'b0, 20, 0, "R2 narrow write 20");
    send(3'd1, 1'b0, 19, 0, "R4 narrow write 19");
    send(3'd1, 1'b0, 21, 0, "R4 narrow write 21");
    send(3'd1, 1'b1, 27, 0, "R3 wide write 27");
    send(3'd1, 1'b1, 26, 0, "R4 wide write 26");
    send(3'd1, 1'b1, 20, 0, "R4 wide write 20");
    send(3'd2, 1'b0, 12, 0, "R5 narrow erase 12");
    send(3'd2, 1'b1, 11, 0, "R5 wide erase 11");
    send(3'd3, 1'b1, 11, 0, "R5 wide erase-all 11");
    send(3'd3, 1'b0, 13, 0, "R5 narrow erase-all 13");
    send(3'd4, 1'b0, 20, 0, "R6 narrow write-all 20");
    send(3'd4, 1'b1, 27, 0, "R6 wide write-all 27");
    send(3'd4, 1'b1, 28, 0, "R6 wide write-all 28");
    send(3'd0, 1'b0, 20, 0, "R7 read 20");
    send(3'd0, 1'b1, 5, 0, "R7 read 5");
    send(3'd5, 1'b0, 12, 0, "R7 enable");
    send(3'd6, 1'b1, 11, 0, "R7 disable");
    send(3'd7, 1'b0, 20, 0, "R7 spare");
    send(3'd1, 1'b0, 52, 0, "R8 narrow write 52");
    send(3'd1, 1'b1, 60, 0, "R8 wide write 60");
    send(3'd1, 1'b0, 20, 1, "R11 narrow write last clock with fall");
    send(3'd2, 1'b1, 11, 1, "R11 wide erase last clock with fall");

    // R9: fall with no start
    cmd = 3'd1; org = 1'b0;
    step(0, 1, 0, "R9 unarmed");
    step(0, 0, 1, "R9 unarmed");
    step(0, 0, 0, "R9 unarmed");
    step(0, 0, 0, "R9 unarmed");

    // R10: restart mid-command, then an exact 20-clock write
    step(1, 1, 0, "R10 restart");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R10 restart");
    send(3'd1, 1'b0, 20, 0, "R10 restart then 20");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule